// File: doc/BRIEF.md
# Map-Space Register Access Port

This block sits between the processor's bus and the address-translation hardware. It turns privileged accesses made with the map-space function code into reads and writes of translation entries and of a few system registers. For any other function code it stays silent. Map-space accesses carry an ordinary byte address. The bits above the 2 KB page offset name the virtual page whose entry is touched. That entry is always looked up through the user context, even when the supervisor context holds a different value. The lowest four address bits pick the target: the page map, the segment map, one of the two context registers, the identification store, the diagnostic lamp register, the fault-cause register or the system enable register.

Every accepted map-space access gets a registered response exactly one cycle later. Accesses that reach the page map, segment map or identification store drive a single-cycle entry port toward the translation arrays. That port expects the array's read data back in the same cycle. The context, lamp and enable values are driven out continuously for use by the rest of the translation path.

Top module: `map_space_port`

## Requirements
- R1: Only a request with function code 3 (map space) is decoded. A request with any other code (1/2 user data/program, 5/6 supervisor data/program, 7 CPU space) produces no response, no array request and no register change.
- R2: A map-space request made while `req_super` is 0 returns a response with `rsp_err`=1 and `rsp_rdata`=0. It raises no array request and changes no register.
- R3: Offset 0 addresses the page map. It raises `arr_req` with `arr_sel`=0, `arr_vpage`=`req_addr[23:11]`, `arr_ctx` equal to the user context, `arr_we`=`req_write` and `arr_wdata`=`req_wdata`. A read returns all 32 bits of `arr_rdata`.
- R4: Offset 5 addresses the segment map in the same way as R3, with `arr_sel`=1. A read returns `arr_rdata[7:0]` zero-extended.
- R5: Offset 6 is the supervisor context and offset 7 is the user context. A write stores only `req_wdata[2:0]`. A read returns the stored 3 bits with all higher bits 0. Both reset to 0 and appear on `sup_ctx` and `usr_ctx`.
- R6: Offset 8 reads the identification store through `arr_sel`=2 and returns `arr_rdata[7:0]` zero-extended. A write there keeps `arr_we` at 0.
- R7: Offset 0xB is the lamp register. It is active low (0 lights a lamp), resets to 0xFF (all dark), reads back its value and drives `lamp_n`.
- R8: Offset 0xF is the system enable register. It resets to 0x00, reads back its value and drives `sys_enable`.
- R9: Offset 0xD is the fault-cause register. It loads `fault_cause` in every cycle where `fault_valid` is 1. A read returns the held value and clears it, unless a new fault arrives in the same cycle, in which case the new cause is kept. Writes to it have no effect.
- R10: Any other offset, or any address with a nonzero bit in `req_addr[10:4]`, reads as 0 without error. Writes there have no effect, and no array request is raised.
- R11: Each accepted map-space request yields `rsp_valid`=1 in the following cycle only. Register writes are visible to the next request. Write responses carry `rsp_rdata`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor access present this cycle |
| req_fc | input | 3 | Function code of the access |
| req_super | input | 1 | Processor is in supervisor state |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Byte address of the access |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's map access |
| rsp_err | output | 1 | Access rejected for lack of privilege |
| rsp_rdata | output | 32 | Read data |
| arr_req | output | 1 | Translation array access this cycle |
| arr_we | output | 1 | Array write strobe |
| arr_sel | output | 2 | 0 page map, 1 segment map, 2 identification store |
| arr_ctx | output | 3 | Context used for the lookup (user context) |
| arr_vpage | output | 13 | Virtual page number selecting the entry |
| arr_wdata | output | 32 | Entry write data |
| arr_rdata | input | 32 | Entry read data, same cycle |
| fault_valid | input | 1 | Translator reports a fault this cycle |
| fault_cause | input | 8 | Fault cause code |
| sup_ctx | output | 3 | Supervisor context |
| usr_ctx | output | 3 | User context |
| lamp_n | output | 8 | Diagnostic lamps, active low |
| sys_enable | output | 8 | System enable bits |

## Verification
The case hardest to reach from the ports is a read of the fault-cause register that lands in the same cycle as a new fault report. The stimulus first loads one cause through a fault report during an unrelated access. It then issues the read while driving a second cause, and a further read must return the second cause rather than zero. The bench also sets the two contexts to different values before any page- or segment-map access, so that a lookup through the wrong context shows up on `arr_ctx`. It drives addresses with reserved bits set and the map offsets repeated under other function codes, so that decoding that is too loose becomes visible.

// File: rtl/map_port_pkg.sv
package map_port_pkg;

    localparam int OFF_W = 4;
    localparam logic [2:0] FC_MAPSPACE = 3'd3;

    localparam logic [OFF_W-1:0] OFS_PAGE  = 4'h0;
    localparam logic [OFF_W-1:0] OFS_SEG   = 4'h5;
    localparam logic [OFF_W-1:0] OFS_SCTX  = 4'h6;
    localparam logic [OFF_W-1:0] OFS_UCTX  = 4'h7;
    localparam logic [OFF_W-1:0] OFS_IDST  = 4'h8;
    localparam logic [OFF_W-1:0] OFS_LAMP  = 4'hB;
    localparam logic [OFF_W-1:0] OFS_FAULT = 4'hD;
    localparam logic [OFF_W-1:0] OFS_ENAB  = 4'hF;

    typedef enum logic [3:0] {
        T_NONE, T_PAGE, T_SEG, T_SCTX, T_UCTX, T_IDST, T_LAMP, T_FAULT, T_ENAB
    } target_e;

    typedef enum logic [1:0] {
        ASEL_PAGE = 2'd0,
        ASEL_SEG  = 2'd1,
        ASEL_ID   = 2'd2
    } arr_sel_e;

    typedef struct packed {
        logic    map_hit;
        logic    priv_ok;
        logic    write;
        target_e tgt;
    } acc_t;

    function automatic target_e decode_offset(input logic [OFF_W-1:0] off,
                                              input logic resv_clear);
        target_e t;
        t = T_NONE;
        if (resv_clear) begin
            case (off)
                OFS_PAGE:  t = T_PAGE;
                OFS_SEG:   t = T_SEG;
                OFS_SCTX:  t = T_SCTX;
                OFS_UCTX:  t = T_UCTX;
                OFS_IDST:  t = T_IDST;
                OFS_LAMP:  t = T_LAMP;
                OFS_FAULT: t = T_FAULT;
                OFS_ENAB:  t = T_ENAB;
                default:   t = T_NONE;
            endcase
        end
        return t;
    endfunction

    function automatic logic tgt_is_array(input target_e t);
        return (t == T_PAGE) || (t == T_SEG) || (t == T_IDST);
    endfunction

    function automatic arr_sel_e arr_sel_of(input target_e t);
        arr_sel_e s;
        case (t)
            T_SEG:   s = ASEL_SEG;
            T_IDST:  s = ASEL_ID;
            default: s = ASEL_PAGE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/map_decode.sv
module map_decode
    import map_port_pkg::*;
#(
    parameter int PG_SHIFT = 11
) (
    input  logic                req_valid,
    input  logic [2:0]          req_fc,
    input  logic                req_super,
    input  logic                req_write,
    input  logic [PG_SHIFT-1:0] page_off,
    output acc_t                acc
);
    logic resv_clear;

    always_comb begin
        resv_clear  = (page_off[PG_SHIFT-1:OFF_W] == '0);
        acc.map_hit = req_valid && (req_fc == FC_MAPSPACE);
        acc.priv_ok = acc.map_hit && req_super;
        acc.write   = req_write;
        acc.tgt     = acc.priv_ok ? decode_offset(page_off[OFF_W-1:0], resv_clear)
                                  : T_NONE;
    end

endmodule

// File: rtl/map_ctx_regs.sv
module map_ctx_regs #(
    parameter int CTX_W = 3,
    parameter int N_CTX = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [N_CTX-1:0]            we,
    input  logic [CTX_W-1:0]            wdata,
    output logic [N_CTX-1:0][CTX_W-1:0] ctx_q
);
    for (genvar i = 0; i < N_CTX; i++) begin : g_ctx
        always_ff @(posedge clk) begin
            if (rst)
                ctx_q[i] <= '0;
            else if (we[i])
                ctx_q[i] <= wdata;
        end

        p_ctx_hold_r5: assert property (@(posedge clk) disable iff (rst)
            !we[i] |=> $stable(ctx_q[i]));
        p_ctx_load_r5: assert property (@(posedge clk) disable iff (rst)
            we[i] |=> (ctx_q[i] == $past(wdata)));
    end

endmodule

// File: rtl/map_sys_regs.sv
module map_sys_regs #(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we_lamp,
    input  logic             we_enab,
    input  logic             rd_fault,
    input  logic [REG_W-1:0] wdata,
    input  logic             fault_valid,
    input  logic [REG_W-1:0] fault_cause,
    output logic [REG_W-1:0] lamp_q,
    output logic [REG_W-1:0] enab_q,
    output logic [REG_W-1:0] fault_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            lamp_q <= '1;
            enab_q <= '0;
        end else begin
            if (we_lamp) lamp_q <= wdata;
            if (we_enab) enab_q <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            fault_q <= '0;
        else if (fault_valid)
            fault_q <= fault_cause;
        else if (rd_fault)
            fault_q <= '0;
    end

    p_lamp_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !we_lamp |=> $stable(lamp_q));
    p_enab_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !we_enab |=> $stable(enab_q));
    p_fault_capture_r9: assert property (@(posedge clk) disable iff (rst)
        fault_valid |=> (fault_q == $past(fault_cause)));
    p_fault_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_fault && !fault_valid) |=> (fault_q == '0));

endmodule

// File: rtl/map_space_port.sv
module map_space_port
    import map_port_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int DATA_W   = 32,
    parameter int PG_SHIFT = 11,
    parameter int CTX_W    = 3,
    parameter int SEG_W    = 8,
    parameter int ID_W     = 8,
    parameter int REG_W    = 8,
    localparam int VPAGE_W = ADDR_W - PG_SHIFT
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [2:0]         req_fc,
    input  logic               req_super,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               rsp_valid,
    output logic               rsp_err,
    output logic [DATA_W-1:0]  rsp_rdata,
    output logic               arr_req,
    output logic               arr_we,
    output logic [1:0]         arr_sel,
    output logic [CTX_W-1:0]   arr_ctx,
    output logic [VPAGE_W-1:0] arr_vpage,
    output logic [DATA_W-1:0]  arr_wdata,
    input  logic [DATA_W-1:0]  arr_rdata,
    input  logic               fault_valid,
    input  logic [REG_W-1:0]   fault_cause,
    output logic [CTX_W-1:0]   sup_ctx,
    output logic [CTX_W-1:0]   usr_ctx,
    output logic [REG_W-1:0]   lamp_n,
    output logic [REG_W-1:0]   sys_enable
);
    localparam int CTX_SUP = 0;
    localparam int CTX_USR = 1;

    acc_t                   acc;
    logic [1:0][CTX_W-1:0]  ctx_q;
    logic [1:0]             ctx_we;
    logic                   do_write;
    logic                   rd_fault;
    logic [REG_W-1:0]       lamp_q, enab_q, fault_q;
    logic [DATA_W-1:0]      rd_mux;

    map_decode #(.PG_SHIFT(PG_SHIFT)) u_dec (
        .req_valid (req_valid),
        .req_fc    (req_fc),
        .req_super (req_super),
        .req_write (req_write),
        .page_off  (req_addr[PG_SHIFT-1:0]),
        .acc       (acc)
    );

    assign do_write       = acc.priv_ok && acc.write;
    assign ctx_we[CTX_SUP] = do_write && (acc.tgt == T_SCTX);
    assign ctx_we[CTX_USR] = do_write && (acc.tgt == T_UCTX);
    assign rd_fault        = acc.priv_ok && !acc.write && (acc.tgt == T_FAULT);

    map_ctx_regs #(.CTX_W(CTX_W), .N_CTX(2)) u_ctx (
        .clk   (clk),
        .rst   (rst),
        .we    (ctx_we),
        .wdata (req_wdata[CTX_W-1:0]),
        .ctx_q (ctx_q)
    );

    map_sys_regs #(.REG_W(REG_W)) u_sys (
        .clk         (clk),
        .rst         (rst),
        .we_lamp     (do_write && (acc.tgt == T_LAMP)),
        .we_enab     (do_write && (acc.tgt == T_ENAB)),
        .rd_fault    (rd_fault),
        .wdata       (req_wdata[REG_W-1:0]),
        .fault_valid (fault_valid),
        .fault_cause (fault_cause),
        .lamp_q      (lamp_q),
        .enab_q      (enab_q),
        .fault_q     (fault_q)
    );

    assign sup_ctx    = ctx_q[CTX_SUP];
    assign usr_ctx    = ctx_q[CTX_USR];
    assign lamp_n     = lamp_q;
    assign sys_enable = enab_q;

    // Entry port toward the translation arrays; lookup always via user context.
    always_comb begin
        arr_req   = tgt_is_array(acc.tgt);
        arr_we    = arr_req && acc.write && (acc.tgt != T_IDST);
        arr_sel   = arr_sel_of(acc.tgt);
        arr_ctx   = ctx_q[CTX_USR];
        arr_vpage = req_addr[ADDR_W-1:PG_SHIFT];
        arr_wdata = req_wdata;
    end

    always_comb begin
        rd_mux = '0;
        if (!acc.write) begin
            case (acc.tgt)
                T_PAGE:  rd_mux = arr_rdata;
                T_SEG:   rd_mux = DATA_W'(arr_rdata[SEG_W-1:0]);
                T_IDST:  rd_mux = DATA_W'(arr_rdata[ID_W-1:0]);
                T_SCTX:  rd_mux = DATA_W'(ctx_q[CTX_SUP]);
                T_UCTX:  rd_mux = DATA_W'(ctx_q[CTX_USR]);
                T_LAMP:  rd_mux = DATA_W'(lamp_q);
                T_FAULT: rd_mux = DATA_W'(fault_q);
                T_ENAB:  rd_mux = DATA_W'(enab_q);
                default: rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= acc.map_hit;
            rsp_err   <= acc.map_hit && !acc.priv_ok;
            rsp_rdata <= rd_mux;
        end
    end

    p_rsp_follows_r11: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_fc == FC_MAPSPACE) |=> rsp_valid);
    p_no_rsp_r1: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_fc == FC_MAPSPACE) |=> !rsp_valid);
    p_user_err_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_fc == FC_MAPSPACE && !req_super) |=> (rsp_err && rsp_rdata == '0));
    p_user_noarr_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_super) |-> !arr_req);
    p_unlisted_r10: assert property (@(posedge clk) disable iff (rst)
        (acc.priv_ok && acc.tgt == T_NONE) |=> (rsp_rdata == '0 && !rsp_err));
    p_id_nowrite_r6: assert property (@(posedge clk) disable iff (rst)
        (arr_req && arr_sel == 2'd2) |-> !arr_we);

endmodule

// File: tb/sim_map_space_port.sv
module sim_map_space_port;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [2:0]  req_fc = 3'd0;
    logic        req_super = 1'b0;
    logic        req_write = 1'b0;
    logic [23:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    logic        arr_req, arr_we;
    logic [1:0]  arr_sel;
    logic [2:0]  arr_ctx;
    logic [12:0] arr_vpage;
    logic [31:0] arr_wdata;
    logic [31:0] arr_rdata;
    logic        fault_valid = 1'b0;
    logic [7:0]  fault_cause = '0;
    logic [2:0]  sup_ctx, usr_ctx;
    logic [7:0]  lamp_n, sys_enable;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    int m_sctx, m_uctx, m_lamp, m_enab, m_fault;

    always #10 clk = ~clk;

    map_space_port u0 (.*);

    function automatic logic [31:0] fake_entry(input int sel, input int ctx, input int vp);
        return 32'hC000_0005 | (32'(sel) << 26) | (32'(ctx) << 20) | (32'(vp) << 4);
    endfunction

    // Behavioural array: returns a pattern derived from the lookup key.
    always_comb arr_rdata = fake_entry(int'(arr_sel), int'(arr_ctx), int'(arr_vpage));

    task automatic chk(input string rq, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic chk_state(input string rq);
        chk(rq, "sup_ctx", 32'(sup_ctx), 32'(m_sctx));
        chk(rq, "usr_ctx", 32'(usr_ctx), 32'(m_uctx));
        chk(rq, "lamp_n", 32'(lamp_n), 32'(m_lamp));
        chk(rq, "sys_enable", 32'(sys_enable), 32'(m_enab));
    endtask

    task automatic acc(input string rq, input logic [2:0] fc, input logic sup,
                       input logic [23:0] addr, input logic wr, input logic [31:0] wd,
                       input logic fv, input logic [7:0] fcause);
        bit is_map, ok, resv, exp_arr;
        int off, vp, exp_sel;
        logic [31:0] exp_rd;
        req_valid = 1'b1; req_fc = fc; req_super = sup; req_addr = addr;
        req_write = wr; req_wdata = wd; fault_valid = fv; fault_cause = fcause;
        #1;
        is_map = (fc == 3'd3);
        ok     = is_map && sup;
        resv   = (addr[10:4] == 7'd0);
        off    = resv ? int'(addr[3:0]) : -1;
        vp     = int'(addr[23:11]);
        exp_arr = ok && (off == 0 || off == 5 || off == 8);
        exp_sel = (off == 5) ? 1 : (off == 8) ? 2 : 0;
        chk(rq, "arr_req", 32'(arr_req), 32'(exp_arr));
        if (exp_arr) begin
            chk(rq, "arr_sel", 32'(arr_sel), 32'(exp_sel));
            chk(rq, "arr_ctx(user)", 32'(arr_ctx), 32'(m_uctx));
            chk(rq, "arr_vpage", 32'(arr_vpage), 32'(vp));
            chk(rq, "arr_we", 32'(arr_we), 32'(wr && off != 8));
            if (wr) chk(rq, "arr_wdata", arr_wdata, wd);
        end
        exp_rd = 32'd0;
        if (ok && !wr) begin
            case (off)
                0:  exp_rd = fake_entry(0, m_uctx, vp);
                5:  exp_rd = fake_entry(1, m_uctx, vp) & 32'hFF;
                8:  exp_rd = fake_entry(2, m_uctx, vp) & 32'hFF;
                6:  exp_rd = 32'(m_sctx);
                7:  exp_rd = 32'(m_uctx);
                11: exp_rd = 32'(m_lamp);
                13: exp_rd = 32'(m_fault);
                15: exp_rd = 32'(m_enab);
                default: exp_rd = 32'd0;
            endcase
        end
        if (ok && wr) begin
            case (off)
                6:  m_sctx = int'(wd[2:0]);
                7:  m_uctx = int'(wd[2:0]);
                11: m_lamp = int'(wd[7:0]);
                15: m_enab = int'(wd[7:0]);
                default: ;
            endcase
        end
        if (fv) m_fault = int'(fcause);
        else if (ok && !wr && off == 13) m_fault = 0;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; fault_valid = 1'b0;
        chk(rq, "rsp_valid", 32'(rsp_valid), 32'(is_map));
        if (is_map) begin
            chk(rq, "rsp_err", 32'(rsp_err), 32'(!sup));
            chk(rq, "rsp_rdata", rsp_rdata, exp_rd);
        end
        chk_state(rq);
    endtask

    task automatic idle(input string rq);
        @(posedge clk);
        @(negedge clk);
        chk(rq, "rsp_valid idle", 32'(rsp_valid), 32'd0);
        chk_state(rq);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        m_sctx = 0; m_uctx = 0; m_lamp = 8'hFF; m_enab = 0; m_fault = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // Reset values (R5 R7 R8)
        chk("R11", "rsp_valid reset", 32'(rsp_valid), 32'd0);
        chk_state("R5 R7 R8 reset");
        // Context writes keep the low 3 bits; reads zero high bits (R5)
        acc("R5", 3'd3, 1, 24'h000007, 1, 32'hFFFF_FFFD, 0, 0);
        acc("R5", 3'd3, 1, 24'h000006, 1, 32'h0000_0012, 0, 0);
        acc("R5", 3'd3, 1, 24'h000007, 0, 0, 0, 0);
        acc("R5", 3'd3, 1, 24'h3F8006, 0, 0, 0, 0);
        // Page map through user context (R3)
        acc("R3", 3'd3, 1, 24'h123800, 0, 0, 0, 0);
        acc("R3", 3'd3, 1, 24'hFFF800, 1, 32'hDEAD_BEEF, 0, 0);
        // Segment map (R4)
        acc("R4", 3'd3, 1, 24'h7FF805, 0, 0, 0, 0);
        acc("R4", 3'd3, 1, 24'h008005, 1, 32'h0000_00A7, 0, 0);
        // Identification store (R6)
        acc("R6", 3'd3, 1, 24'h000808, 0, 0, 0, 0);
        acc("R6", 3'd3, 1, 24'h001008, 1, 32'h55, 0, 0);
        // Lamps and enable (R7 R8)
        acc("R7", 3'd3, 1, 24'h00000B, 1, 32'h1234_565A, 0, 0);
        acc("R7", 3'd3, 1, 24'h00000B, 0, 0, 0, 0);
        acc("R8", 3'd3, 1, 24'h00000F, 1, 32'h81, 0, 0);
        acc("R8", 3'd3, 1, 24'h00000F, 0, 0, 0, 0);
        // Fault register (R9)
        acc("R9", 3'd1, 0, 24'h000000, 0, 0, 1, 8'h3C);
        acc("R9", 3'd3, 1, 24'h00000D, 1, 32'hFF, 0, 0);
        acc("R9", 3'd3, 1, 24'h00000D, 0, 0, 0, 0);
        acc("R9", 3'd3, 1, 24'h00000D, 0, 0, 0, 0);
        acc("R9", 3'd5, 1, 24'h000000, 0, 0, 1, 8'h42);
        acc("R9", 3'd3, 1, 24'h00000D, 0, 0, 1, 8'h11);
        acc("R9", 3'd3, 1, 24'h00000D, 0, 0, 0, 0);
        // User privilege rejected (R2)
        acc("R2", 3'd3, 0, 24'h000007, 1, 32'h6, 0, 0);
        acc("R2", 3'd3, 0, 24'h123800, 0, 0, 0, 0);
        acc("R2", 3'd3, 0, 24'h00000B, 1, 32'h00, 0, 0);
        // Other function codes ignored (R1)
        acc("R1", 3'd5, 1, 24'h000007, 1, 32'h3, 0, 0);
        acc("R1", 3'd7, 1, 24'h123800, 0, 0, 0, 0);
        acc("R1", 3'd2, 0, 24'h00000F, 1, 32'hFF, 0, 0);
        acc("R1", 3'd6, 1, 24'h00000B, 1, 32'h00, 0, 0);
        // Unlisted offsets and reserved bits (R10)
        acc("R10", 3'd3, 1, 24'h000003, 0, 0, 0, 0);
        acc("R10", 3'd3, 1, 24'h00000C, 1, 32'hFF, 0, 0);
        acc("R10", 3'd3, 1, 24'h000017, 1, 32'h1, 0, 0);
        acc("R10", 3'd3, 1, 24'h000010, 0, 0, 0, 0);
        acc("R10", 3'd3, 1, 24'h00000B, 0, 0, 0, 0);
        // Single-cycle response and back-to-back visibility (R11)
        acc("R11", 3'd3, 1, 24'h000007, 1, 32'h2, 0, 0);
        acc("R11", 3'd3, 1, 24'h456000, 0, 0, 0, 0);
        idle("R11");
        finish_run();
    end

endmodule